// File: doc/BRIEF.md
# Two-Lane Multiply-Rotate Hash Accumulator

This block is the bulk-absorption core of a 64-bit non-cryptographic hash. It keeps two 64-bit lanes. Each update takes one 128-bit message word. A start pulse seeds both lanes from fixed constants mixed with a 64-bit seed. After that, each accepted word is added into the lanes. Each lane is then rewritten as the product of its own two 32-bit halves, plus the other lane's sum with its halves exchanged. This cross-lane, half-swapped add-back keeps repeated updates, including updates with all-zero data, from driving the state toward zero.

Upstream logic supplies words through a valid/ready handshake. It marks the final word of a message with a last flag and gives the total byte length. Messages are at least 16 bytes long. The final word always covers the last 16 bytes of the message, even when it overlaps the word before it. When the last word has been absorbed, a length term is folded into lane 0 and the result is flagged valid. Short messages and the final avalanche mixer belong to neighbouring blocks.

The multiplier is pipelined by a parameter. Each update needs the state left by the previous one, so only one word is in flight at a time. The lanes are visible on the outputs at all times.

Top module: `mix_accum`

## Requirements
- R1: While reset is high and after it, until the first start, in_ready and out_valid are 0 and both output lanes are zero.
- R2: A start pulse sets lane 0 to 0x736f6d6570736575 XOR seed and lane 1 to 0x646f72616e646f6d XOR seed, and raises in_ready on the next cycle. Start takes priority over everything else and aborts a message in progress.
- R3: A word is split little-endian: in_data[63:0] (bytes 0 to 7) feeds lane 0 and in_data[127:64] (bytes 8 to 15) feeds lane 1.
- R4: On an accepted word, with x0 = lane0 + d0 and x1 = lane1 + d1 (modulo 2^64), the new lane 0 is x0[31:0]*x0[63:32] + {x1[31:0], x1[63:32]}, and the new lane 1 is x1[31:0]*x1[63:32] + {x0[31:0], x0[63:32]}, all modulo 2^64.
- R5: After the clock edge that accepts a word, in_ready is 0 and returns to 1 exactly MUL_STAGES+1 edges later, with the updated lanes on the outputs.
- R6: When the accepted word carries in_last, the updated lane 0 is additionally XORed with the zero-extended low 32 bits of in_len*2654435761. out_valid rises on the same edge as the update, and in_ready stays 0.
- R7: While out_valid is 1 and no start arrives, out_valid stays 1 and both lanes hold their values.
- R8: A long run of all-zero words from a seeded state follows the R4 arithmetic at every step, and the state never collapses to zero.
- R9: in_valid is ignored while in_ready is 0. While in_ready is 1 and no word is offered, the lanes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Seed the lanes and open a new message |
| seed | input | 64 | Seed XORed into both initial lanes |
| in_valid | input | 1 | A message word is offered |
| in_ready | output | 1 | The accumulator can take a word |
| in_data | input | 128 | Message word, little-endian |
| in_last | input | 1 | The offered word is the message's final 16 bytes |
| in_len | input | LEN_W | Total message length in bytes, sampled with the last word |
| out_valid | output | 1 | The lanes hold a finished result |
| out_lane0 | output | 64 | Lane 0 state or result |
| out_lane1 | output | 64 | Lane 1 state or result |

## Verification
The bench sweeps message lengths from 16 to 127 bytes with varied word data. After every word it compares both lanes with an arithmetic model. A design that dropped the half swap, used the same lane's sum, or swapped the byte order would diverge on the first word. A run of 64 all-zero words checks each step and checks that the state stays nonzero; a design without the cross-lane swap decays to zero within such a run. The bench also offers noise on in_valid while a word is in flight, aborts a message with start, and measures the handshake latency. A design that took a second word early, failed to fold the length, or let the result drift after completion would fail one of these checks.

// File: rtl/mixacc_pkg.sv
package mixacc_pkg;

    localparam int LANE_W = 64;
    localparam int HALF_W = LANE_W / 2;

    localparam logic [LANE_W-1:0] INIT_LANE0 = 64'h736f6d6570736575;
    localparam logic [LANE_W-1:0] INIT_LANE1 = 64'h646f72616e646f6d;
    localparam logic [HALF_W-1:0] LEN_MULT   = 32'h9E3779B1;

    typedef struct packed {
        logic [LANE_W-1:0] hi_lane;
        logic [LANE_W-1:0] lo_lane;
    } lane_pair_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPEN,
        PH_BUSY,
        PH_DONE
    } phase_e;

    function automatic logic [LANE_W-1:0] swap_halves(input logic [LANE_W-1:0] v);
        return {v[HALF_W-1:0], v[LANE_W-1:HALF_W]};
    endfunction

    function automatic logic [LANE_W-1:0] len_fold(input logic [LANE_W-1:0] len);
        logic [LANE_W-1:0] prod;
        prod = len * {{HALF_W{1'b0}}, LEN_MULT};
        return {{HALF_W{1'b0}}, prod[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/mixacc_lane_mul.sv
module mixacc_lane_mul #(
    parameter int HALF_W = 32,
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic [HALF_W-1:0]   op_a,
    input  logic [HALF_W-1:0]   op_b,
    output logic [2*HALF_W-1:0] prod
);
    localparam int PROD_W = 2 * HALF_W;

    logic [PROD_W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        pipe_q[0] <= PROD_W'(op_a) * PROD_W'(op_b);
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign prod = pipe_q[STAGES-1];

endmodule

// File: rtl/mixacc_ctrl.sv
module mixacc_ctrl
    import mixacc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic accept,
    output logic commit,
    output logic commit_last
);
    localparam int CNT_W = $clog2(STAGES + 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   wait_q;
    logic               last_q;

    assign in_ready    = (phase_q == PH_OPEN);
    assign out_valid   = (phase_q == PH_DONE);
    assign load        = start;
    assign accept      = in_ready && in_valid && !start;
    assign commit      = (phase_q == PH_BUSY) && (wait_q == '0) && !start;
    assign commit_last = commit && last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            wait_q  <= '0;
            last_q  <= 1'b0;
        end else if (start) begin
            phase_q <= PH_OPEN;
            wait_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_OPEN: begin
                    if (in_valid) begin
                        phase_q <= PH_BUSY;
                        wait_q  <= CNT_W'(STAGES);
                        last_q  <= in_last;
                    end
                end
                PH_BUSY: begin
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end else begin
                        phase_q <= last_q ? PH_DONE : PH_OPEN;
                    end
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

endmodule

// File: rtl/mix_accum.sv
module mix_accum
    import mixacc_pkg::*;
#(
    parameter int LEN_W      = 32,
    parameter int MUL_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       seed,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [127:0]      in_data,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    output logic [63:0]       out_lane0,
    output logic [63:0]       out_lane1
);
    localparam int NLANES = 2;

    logic load, accept, commit, commit_last;

    lane_pair_t        st_q;
    lane_pair_t        sum_q;
    logic [LEN_W-1:0]  len_q;
    logic [LANE_W-1:0] sum_lane [NLANES];
    logic [LANE_W-1:0] prod_lane [NLANES];
    lane_pair_t        next_st;

    mixacc_ctrl #(.STAGES(MUL_STAGES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .load        (load),
        .accept      (accept),
        .commit      (commit),
        .commit_last (commit_last)
    );

    assign sum_lane[0] = sum_q.lo_lane;
    assign sum_lane[1] = sum_q.hi_lane;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        mixacc_lane_mul #(.HALF_W(HALF_W), .STAGES(MUL_STAGES)) u_mul (
            .clk  (clk),
            .op_a (sum_lane[i][HALF_W-1:0]),
            .op_b (sum_lane[i][LANE_W-1:HALF_W]),
            .prod (prod_lane[i])
        );
    end

    always_comb begin
        next_st.lo_lane = prod_lane[0] + swap_halves(sum_lane[1]);
        next_st.hi_lane = prod_lane[1] + swap_halves(sum_lane[0]);
        if (commit_last) begin
            next_st.lo_lane = next_st.lo_lane ^ len_fold(LANE_W'(len_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            sum_q <= '0;
            len_q <= '0;
        end else if (load) begin
            st_q.lo_lane <= INIT_LANE0 ^ seed;
            st_q.hi_lane <= INIT_LANE1 ^ seed;
        end else if (accept) begin
            sum_q.lo_lane <= st_q.lo_lane + in_data[63:0];
            sum_q.hi_lane <= st_q.hi_lane + in_data[127:64];
            len_q         <= in_len;
        end else if (commit) begin
            st_q <= next_st;
        end
    end

    assign out_lane0 = st_q.lo_lane;
    assign out_lane1 = st_q.hi_lane;

endmodule

// File: rtl/mixacc_chk.sv
module mixacc_chk
    import mixacc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [63:0] seed,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [63:0] out_lane0,
    input logic [63:0] out_lane1
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!in_ready && !out_valid && out_lane0 == '0 && out_lane1 == '0)); // R1

    AST_START_SEEDS: assert property (@(posedge clk) disable iff (rst)
        start |=> (in_ready && out_lane0 == (INIT_LANE0 ^ $past(seed))
                   && out_lane1 == (INIT_LANE1 ^ $past(seed)))); // R2

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !start) |=> !in_ready); // R5

    AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !start) |=> (out_valid && $stable(out_lane0) && $stable(out_lane1))); // R7

    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid && !start) |=> (in_ready && $stable(out_lane0) && $stable(out_lane1))); // R9

endmodule

bind mix_accum mixacc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .seed      (seed),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_lane0 (out_lane0),
    .out_lane1 (out_lane1)
);

// File: tb/mix_accum_tb.sv
module mix_accum_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int LEN_W      = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [63:0]       seed = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [127:0]      in_data = '0;
    logic              in_last = 1'b0;
    logic [LEN_W-1:0]  in_len = '0;
    logic              out_valid;
    logic [63:0]       out_lane0, out_lane1;

    int nchk = 0;
    int nfail = 0;
    logic [63:0]  rng = 64'h0123456789ABCDEF;
    logic [127:0] mdl;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mix_accum #(.LEN_W(LEN_W), .MUL_STAGES(LAT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .seed(seed),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_len(in_len), .out_valid(out_valid),
        .out_lane0(out_lane0), .out_lane1(out_lane1)
    );

    function automatic logic [127:0] mdl_step(input logic [127:0] st, input logic [127:0] d);
        logic [63:0] x0, x1, m0, m1;
        x0 = st[63:0] + d[63:0];
        x1 = st[127:64] + d[127:64];
        m0 = {32'b0, x0[31:0]} * {32'b0, x0[63:32]};
        m1 = {32'b0, x1[31:0]} * {32'b0, x1[63:32]};
        return {m1 + {x0[31:0], x0[63:32]}, m0 + {x1[31:0], x1[63:32]}};
    endfunction

    function automatic logic [63:0] mdl_len(input logic [63:0] len);
        logic [63:0] p;
        p = len * 64'd2654435761;
        return {32'b0, p[31:0]};
    endfunction

    function automatic logic [127:0] mdl_init(input logic [63:0] s);
        return {64'h646f72616e646f6d ^ s, 64'h736f6d6570736575 ^ s};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
    endtask

    task automatic do_start(input logic [63:0] s);
        @(negedge clk);
        start = 1'b1;
        seed  = s;
        @(negedge clk);
        start = 1'b0;
        mdl = mdl_init(s);
        check("R2 seeded lanes", {out_lane1, out_lane0}, mdl);
        check("R2 ready after start", {127'b0, in_ready}, 128'd1);
    endtask

    // Offers one word, waits for it to be absorbed, checks latency and lanes.
    task automatic send(input logic [127:0] d, input bit last, input int len, input bit noisy);
        int k;
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        in_len   = LEN_W'(len);
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        k = 0;
        while (1) begin
            @(negedge clk);
            k++;
            if (in_ready || out_valid) begin
                in_valid = 1'b0;
                break;
            end
            in_valid = noisy;
            in_data  = ~d;
            in_last  = ~last;
            in_len   = LEN_W'(len + 5);
            if (k > LAT + 10) break;
        end
        in_valid = 1'b0;
        check("R5 absorb latency", 128'(k), 128'(LAT + 2));
        mdl = mdl_step(mdl, d);
        if (last) mdl[63:0] = mdl[63:0] ^ mdl_len(64'(len));
        check(last ? "R6 final lanes with length fold" : "R3/R4 lane update",
              {out_lane1, out_lane0}, mdl);
        check(last ? "R6 out_valid on last" : "R5 ready again",
              {126'b0, out_valid, in_ready}, last ? 128'd2 : 128'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {out_lane1, out_lane0}, 128'd0);
        check("R1 reset flags", {126'b0, out_valid, in_ready}, 128'd0);
        rst = 1'b0;
        // R9: words offered before any start are ignored
        in_valid = 1'b1;
        in_data  = {2{64'hDEADBEEFCAFEF00D}};
        in_last  = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("R1 idle after reset lanes", {out_lane1, out_lane0}, 128'd0);
        check("R9 idle ignores in_valid", {126'b0, out_valid, in_ready}, 128'd0);

        // R3: only one lane's half of the word carries data
        do_start(64'h0);
        send({64'h0, 64'h0000000100000002}, 1'b0, 0, 1'b0);
        send({64'hFFFFFFFF00000000, 64'h0}, 1'b1, 32, 1'b0);

        // R9: lanes hold while the port is open and nothing is offered
        do_start(64'h1122334455667788);
        repeat (5) @(negedge clk);
        check("R9 open and idle holds lanes", {out_lane1, out_lane0}, mdl);

        // Length sweep with varied data; odd lengths use noisy in_valid while busy
        for (int len = 16; len < 128; len += 7) begin
            int nw;
            nw = (len + 15) / 16;
            next_rng();
            do_start(rng);
            for (int w = 0; w < nw; w++) begin
                logic [127:0] d;
                next_rng();
                d[63:0] = rng;
                next_rng();
                d[127:64] = rng;
                send(d, w == nw - 1, len, len[0]);
            end
            repeat (3) @(negedge clk);
            check("R7 result held", {out_lane1, out_lane0}, mdl);
            check("R7 out_valid held", {126'b0, out_valid, in_ready}, 128'd2);
        end

        // R8: all-zero words from a seeded state
        do_start(64'h0);
        for (int w = 0; w < 64; w++) begin
            send(128'd0, 1'b0, 0, 1'b0);
            nchk++;
            if ({out_lane1, out_lane0} == 128'd0) begin
                nfail++;
                $display("FAIL R8 zero-feed collapse: actual %h expected nonzero",
                         {out_lane1, out_lane0});
            end
        end
        send(128'd0, 1'b1, 1024, 1'b0);

        // R2: start aborts a message in progress
        do_start(64'hA5A5A5A5A5A5A5A5);
        send({2{64'h0F0F0F0F0F0F0F0F}}, 1'b0, 0, 1'b0);
        in_valid = 1'b1;
        in_data  = {2{64'h1234}};
        in_last  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        do_start(64'h5A5A5A5A5A5A5A5A);
        repeat (LAT + 4) @(negedge clk);
        check("R2 abort leaves fresh seed", {out_lane1, out_lane0}, mdl);
        send({2{64'h77}}, 1'b1, 16, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule